// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Entry Receive Queue

This block turns an idle-high asynchronous serial line into parallel words. It brings the line into the clock domain through a flip-flop synchronizer. It finds the falling edge of a start bit and decides each bit by a three-sample majority vote near the middle of the bit. It then assembles 8 or 9 data bits, least significant bit first, and checks the stop level. A separate baud generator supplies one oversample tick per sixteenth of a bit period.

Completed words go into a two-entry queue. Each entry holds the data byte, the ninth bit and a framing-error flag, so the status shown always belongs to the word at the head of the queue. A data-available flag stays high while any entry is unread. When a word completes with no free slot, a sticky overrun flag is raised and reception halts until the enable input is dropped and raised again.

In 9-bit mode an optional address filter keeps only words whose ninth bit is 1. This lets a receiver on a shared line ignore payload traffic until it is addressed.

Top module: `async_rx_top`

## Requirements
- R1: While idle and enabled, a low level on the synchronized line at an oversample tick starts a frame, and that tick counts as tick 0 of the start bit. The line passes through a two-stage synchronizer that resets to 1.
- R2: Each bit is decided by a majority of the line levels seen at ticks 7, 8 and 9 of the bit, so a glitch that corrupts one of the three samples does not change the received value.
- R3: If the vote on the start bit is high, the start is treated as noise: the receiver returns to idle and no word is produced.
- R4: Data arrives least significant bit first. With `wide_en_i` = 0 a frame carries 8 data bits and the stored ninth bit reads 0. With `wide_en_i` = 1 a ninth bit follows the eighth data bit and is stored in `head_bit9_o`. The mode is taken when the start is detected.
- R5: At the vote on the stop bit, the word is written into the queue and `avail_o` goes high on the following cycle.
- R6: A low vote on the stop bit stores the word with its framing-error flag set to 1. A high vote stores it with the flag set to 0. Either way the word is kept.
- R7: The queue holds two entries in arrival order. `head_data_o`, `head_bit9_o` and `head_ferr_o` always show the oldest unread entry, and they are meaningful only while `avail_o` is 1.
- R8: `avail_o` is 1 while at least one entry is unread and falls only after the last entry is popped. A `pop_i` pulse while the queue is empty has no effect.
- R9: If a word completes while both entries are full and no pop happens in that cycle, `overrun_o` is set, the word is discarded, and no further frames are received.
- R10: `overrun_o` stays set while `rx_en_i` is 1, reading the queue does not clear it, and `rx_en_i` = 0 clears it and returns the receiver to idle.
- R11: With `wide_en_i` = 1 and `addr_only_i` = 1, a word whose ninth bit is 0 is dropped without entering the queue. With `wide_en_i` = 0, `addr_only_i` has no effect.
- R12: When a word completes in the same cycle that `pop_i` removes an entry from a full queue, the pop is applied first, the new word is stored, and no overrun is raised.
- R13: After reset, `avail_o` and `overrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | Oversample tick, 16 per bit period |
| rx_en_i | input | 1 | Receive enable; a low level clears overrun |
| wide_en_i | input | 1 | 1 selects 9 data bits per frame |
| addr_only_i | input | 1 | Keep only words with ninth bit 1 (9-bit mode only) |
| pop_i | input | 1 | Removes the head entry from the queue |
| head_data_o | output | 8 | Data byte of the head entry |
| head_bit9_o | output | 1 | Ninth bit of the head entry |
| head_ferr_o | output | 1 | Framing-error flag of the head entry |
| overrun_o | output | 1 | Sticky overrun flag |
| avail_o | output | 1 | At least one unread entry |

## Verification
Two events can land on the same clock edge: the stop-bit vote that writes a word, and a pop that frees a slot. The bench fills both entries and then starts a third frame. While that frame is in flight, it watches its own reference model and raises `pop_i` on exactly the cycle whose tick carries the stop-bit vote. The result is correct if overrun stays low, the second word moves to the head, and the third word appears after one more pop. A later frame sent into a full queue with no pop must then raise overrun.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  localparam int RX_DATA_W = 8;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic                 ferr;
    logic                 bit9;
    logic [RX_DATA_W-1:0] data;
  } rx_entry_t;

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/async_rx_framer.sv
module async_rx_framer
  import async_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      tick_i,
  input  logic      line_i,
  input  logic      wide_i,
  output logic      done_o,
  output logic      wide_o,
  output rx_entry_t entry_o
);

  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(RX_DATA_W + 2);
  localparam logic [CW-1:0] T_A    = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] T_B    = CW'(OVS / 2);
  localparam logic [CW-1:0] T_VOTE = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] T_LAST = CW'(OVS - 1);
  localparam logic [IW-1:0] N_NARROW = IW'(RX_DATA_W);
  localparam logic [IW-1:0] N_WIDE   = IW'(RX_DATA_W + 1);

  rx_state_e            st_q, st_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic [RX_DATA_W:0]   sh_q, sh_d;
  logic [1:0]           smp_q, smp_d;
  logic                 wide_q, wide_d;
  logic                 vote;

  assign vote = (smp_q[0] & smp_q[1]) | (smp_q[0] & line_i) | (smp_q[1] & line_i);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    smp_d  = smp_q;
    wide_d = wide_q;
    done_o = 1'b0;
    if (!en_i) begin
      st_d = RX_IDLE;
    end else if (tick_i) begin
      if (st_q == RX_IDLE) begin
        if (!line_i) begin
          st_d   = RX_START;
          cnt_d  = CW'(1);
          idx_d  = '0;
          wide_d = wide_i;
        end
      end else begin
        cnt_d = (cnt_q == T_LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == T_A) smp_d[0] = line_i;
        if (cnt_q == T_B) smp_d[1] = line_i;
        if (cnt_q == T_VOTE) begin
          case (st_q)
            RX_START: if (vote) st_d = RX_IDLE;
            RX_DATA: begin
              sh_d[idx_q] = vote;
              idx_d       = idx_q + 1'b1;
            end
            RX_STOP: begin
              done_o = 1'b1;
              st_d   = RX_IDLE;
            end
            default: ;
          endcase
        end
        if (cnt_q == T_LAST) begin
          case (st_q)
            RX_START: st_d = RX_DATA;
            RX_DATA:  if (idx_q == (wide_q ? N_WIDE : N_NARROW)) st_d = RX_STOP;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      smp_q  <= '0;
      wide_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      smp_q  <= smp_d;
      wide_q <= wide_d;
    end
  end

  assign wide_o        = wide_q;
  assign entry_o.data  = sh_q[RX_DATA_W-1:0];
  assign entry_o.bit9  = wide_q & sh_q[RX_DATA_W];
  assign entry_o.ferr  = ~vote;

endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo
  import async_rx_pkg::*;
#(
  parameter  int DEPTH = 2,
  localparam int FW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  rx_entry_t     wdata_i,
  output rx_entry_t     head_o,
  output logic [FW-1:0] fill_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [FW-1:0] fill_q, fill_d;
  logic          do_pop;
  rx_entry_t     slot_w [DEPTH];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop = pop_i && (fill_q != '0);

  always_comb begin
    wr_d   = push_i ? bump(wr_q) : wr_q;
    rd_d   = do_pop ? bump(rd_q) : rd_q;
    fill_d = fill_q + FW'(push_i) - FW'(do_pop);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      fill_q <= fill_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rx_entry_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= '0;
      else if (push_i && (wr_q == PW'(g)))    q <= wdata_i;
    end
    assign slot_w[g] = q;
  end

  assign head_o = slot_w[rd_q];
  assign fill_o = fill_q;

endmodule

// File: rtl/async_rx_top.sv
module async_rx_top
  import async_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DEPTH       = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rxd_i,
  input  logic                 tick_i,
  input  logic                 rx_en_i,
  input  logic                 wide_en_i,
  input  logic                 addr_only_i,
  input  logic                 pop_i,
  output logic [RX_DATA_W-1:0] head_data_o,
  output logic                 head_bit9_o,
  output logic                 head_ferr_o,
  output logic                 overrun_o,
  output logic                 avail_o
);

  localparam int FW = $clog2(DEPTH + 1);

  logic          line_s;
  logic          done, frame_wide, keep, room, push, ovr_set;
  logic          ovr_q, ovr_d;
  logic [FW-1:0] fill;
  rx_entry_t     entry, head;

  async_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (line_s)
  );

  async_rx_framer #(.OVS(OVS)) u_framer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rx_en_i && !ovr_q),
    .tick_i  (tick_i),
    .line_i  (line_s),
    .wide_i  (wide_en_i),
    .done_o  (done),
    .wide_o  (frame_wide),
    .entry_o (entry)
  );

  assign keep    = !(frame_wide && addr_only_i && !entry.bit9);
  assign room    = (fill != FW'(DEPTH)) || pop_i;
  assign push    = done && keep && room;
  assign ovr_set = done && keep && !room;

  always_comb begin
    ovr_d = ovr_q;
    if (!rx_en_i)     ovr_d = 1'b0;
    else if (ovr_set) ovr_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovr_q <= 1'b0;
    else         ovr_q <= ovr_d;
  end

  async_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop_i),
    .wdata_i (entry),
    .head_o  (head),
    .fill_o  (fill)
  );

  assign head_data_o = head.data;
  assign head_bit9_o = head.bit9;
  assign head_ferr_o = head.ferr;
  assign overrun_o   = ovr_q;
  assign avail_o     = (fill != '0);

endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter  int DEPTH = 2,
  localparam int FW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_en_i,
  input logic          pop_i,
  input logic          avail_o,
  input logic          overrun_o,
  input logic [7:0]    head_data_o,
  input logic [FW-1:0] fill
);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= FW'(DEPTH)); // R7

  AST_HEAD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o && !pop_i |=> $stable(head_data_o)); // R7

  AST_AVAIL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail_o && !pop_i |=> avail_o); // R8

  AST_OVR_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(fill) == FW'(DEPTH)); // R9

  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && rx_en_i |=> overrun_o); // R10

  AST_OVR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !overrun_o); // R10

endmodule

bind async_rx_top async_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_en_i     (rx_en_i),
  .pop_i       (pop_i),
  .avail_o     (avail_o),
  .overrun_o   (overrun_o),
  .head_data_o (head_data_o),
  .fill        (fill)
);

// File: tb/test_async_rx_top.sv
module test_async_rx_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic tick = 1'b0;
  logic rx_en = 1'b0;
  logic wide = 1'b0;
  logic addr_only = 1'b0;
  logic pop = 1'b0;
  logic [7:0] head_data;
  logic head_bit9, head_ferr, overrun, avail;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  // behavioural reference model
  int m_st = 0, m_cnt = 0, m_idx = 0;
  bit m_a, m_b, m_v, m_s1 = 1, m_s2 = 1, m_wide, m_ovr = 0;
  bit m_done, m_keep, m_popped, m_en, m_push, m_ferr;
  logic [8:0] m_sh = '0;
  logic [9:0] m_ent;
  logic [9:0] mq [$];

  always #4 clk = ~clk;

  async_rx_top i_async_rx_top (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rxd_i       (rxd),
    .tick_i      (tick),
    .rx_en_i     (rx_en),
    .wide_en_i   (wide),
    .addr_only_i (addr_only),
    .pop_i       (pop),
    .head_data_o (head_data),
    .head_bit9_o (head_bit9),
    .head_ferr_o (head_ferr),
    .overrun_o   (overrun),
    .avail_o     (avail)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) tick = ~tick;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_idx = 0; m_s1 = 1; m_s2 = 1; m_ovr = 0;
      m_sh = '0; m_wide = 0; m_a = 0; m_b = 0;
      mq.delete();
    end else begin
      m_done = 0; m_push = 0;
      m_en = rx_en && !m_ovr;
      if (!m_en) m_st = 0;
      else if (tick) begin
        if (m_st == 0) begin
          if (!m_s2) begin m_st = 1; m_cnt = 1; m_idx = 0; m_wide = wide; end
        end else begin
          if (m_cnt == 7) m_a = m_s2;
          if (m_cnt == 8) m_b = m_s2;
          if (m_cnt == 9) begin
            m_v = (int'(m_a) + int'(m_b) + int'(m_s2)) >= 2;
            if (m_st == 1 && m_v) m_st = 0;
            else if (m_st == 2) begin m_sh[m_idx] = m_v; m_idx++; end
            else if (m_st == 3) begin m_done = 1; m_ferr = !m_v; m_st = 0; end
          end
          if (m_st != 0) begin
            if (m_cnt == 15) begin
              m_cnt = 0;
              if (m_st == 1) m_st = 2;
              else if (m_st == 2 && m_idx == (m_wide ? 9 : 8)) m_st = 3;
            end else m_cnt++;
          end
        end
      end
      m_popped = pop && (mq.size() > 0);
      if (m_done) begin
        m_ent  = {m_ferr, m_wide & m_sh[8], m_sh[7:0]};
        m_keep = !(m_wide && addr_only && !m_sh[8]);
        if (m_keep) begin
          if (mq.size() < 2 || m_popped) m_push = 1;
          else m_ovr = 1;
        end
      end
      if (m_popped) void'(mq.pop_front());
      if (m_push) mq.push_back(m_ent);
      if (!rx_en) m_ovr = 0;
      m_s2 = m_s1;
      m_s1 = rxd;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(avail == (mq.size() != 0), "R8 avail", avail, mq.size() != 0);
      check(overrun == m_ovr, "R9 overrun", overrun, m_ovr);
      if (mq.size() != 0) begin
        check(head_data == mq[0][7:0], "R7 head data", head_data, mq[0][7:0]);
        check(head_bit9 == mq[0][8], "R4 ninth bit", head_bit9, mq[0][8]);
        check(head_ferr == mq[0][9], "R6 framing flag", head_ferr, mq[0][9]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic hold(input logic lvl, input int n);
    rxd = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] v, input int nb, input logic stop, input int gl_bit);
    hold(1'b0, 32);
    for (int i = 0; i < nb; i++) begin
      if (i == gl_bit) begin
        hold(v[i], 15); hold(~v[i], 2); hold(v[i], 15);
      end else hold(v[i], 32);
    end
    hold(stop, 32);
    hold(1'b1, 40);
  endtask

  task automatic pop_once();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic pop_at_stop(output bit hit);
    hit = 0;
    for (int i = 0; i < 3000 && !hit; i++) begin
      @(negedge clk); #1;
      if (m_st == 3 && m_cnt == 9 && tick) begin
        pop = 1'b1; hit = 1;
        @(negedge clk); pop = 1'b0;
      end
    end
  endtask

  initial begin
    bit hit;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(avail == 0, "R13 avail after reset", avail, 0);
    check(overrun == 0, "R13 overrun after reset", overrun, 0);
    rx_en = 1'b1;

    send(9'h0A5, 8, 1'b1, -1);
    check(avail == 1, "R5 word stored", avail, 1);
    check(head_data == 8'hA5, "R1 data 0xA5", head_data, 8'hA5);
    check(head_bit9 == 0, "R4 narrow ninth bit", head_bit9, 0);
    pop_once();
    @(negedge clk);
    check(avail == 0, "R8 emptied", avail, 0);
    pop_once();
    @(negedge clk);
    check(avail == 0 && overrun == 0, "R8 pop on empty", {avail, overrun}, 0);

    hold(1'b0, 6); hold(1'b1, 600);
    check(avail == 0, "R3 start glitch ignored", avail, 0);

    send(9'h03C, 8, 1'b1, 2);
    check(head_data == 8'h3C, "R2 majority vote", head_data, 8'h3C);
    pop_once();

    send(9'h081, 8, 1'b0, -1);
    check(head_ferr == 1 && head_data == 8'h81, "R6 framing error kept", {head_ferr, head_data}, 9'h181);
    send(9'h042, 8, 1'b1, -1);
    check(head_data == 8'h81, "R7 oldest at head", head_data, 8'h81);
    pop_once();
    @(negedge clk);
    check(head_data == 8'h42 && head_ferr == 0, "R7 status follows head", {head_ferr, head_data}, 8'h42);
    pop_once();

    wide = 1'b1;
    send(9'h15A, 9, 1'b1, -1);
    check(head_bit9 == 1 && head_data == 8'h5A, "R4 wide frame", {head_bit9, head_data}, 9'h15A);
    pop_once();
    addr_only = 1'b1;
    send(9'h077, 9, 1'b1, -1);
    check(avail == 0, "R11 ninth bit 0 dropped", avail, 0);
    send(9'h133, 9, 1'b1, -1);
    check(head_data == 8'h33 && head_bit9 == 1, "R11 address kept", {head_bit9, head_data}, 9'h133);
    pop_once();
    wide = 1'b0;
    send(9'h099, 8, 1'b1, -1);
    check(head_data == 8'h99, "R11 filter off in narrow mode", head_data, 8'h99);
    pop_once();
    addr_only = 1'b0;

    send(9'h011, 8, 1'b1, -1);
    send(9'h022, 8, 1'b1, -1);
    fork
      send(9'h033, 8, 1'b1, -1);
      pop_at_stop(hit);
    join
    check(hit == 1, "R12 collision provoked", hit, 1);
    check(overrun == 0, "R12 no overrun on collision", overrun, 0);
    check(head_data == 8'h22, "R12 head after collision", head_data, 8'h22);

    send(9'h044, 8, 1'b1, -1);
    check(overrun == 1, "R9 overrun set", overrun, 1);
    check(head_data == 8'h22, "R9 frame discarded", head_data, 8'h22);
    pop_once();
    @(negedge clk);
    check(head_data == 8'h33, "R12 collided word kept", head_data, 8'h33);
    pop_once();
    @(negedge clk);
    check(overrun == 1, "R10 read keeps overrun", overrun, 1);
    send(9'h066, 8, 1'b1, -1);
    check(avail == 0, "R9 reception halted", avail, 0);

    rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
    check(overrun == 0, "R10 enable toggle clears", overrun, 0);
    send(9'h077, 8, 1'b1, -1);
    check(head_data == 8'h77, "R10 reception resumes", head_data, 8'h77);
    pop_once();
    repeat (4) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule